// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block sits after instruction decode. It turns a mode code and its operands into the address of a memory operand. The operands are a base register value, an index register value, an immediate or displacement, the program counter, an element size and a scale. One unit covers eleven ways of forming an address:

- plain register and immediate operands, which need no memory;
- absolute, register pointer, base plus displacement, base plus index, scaled index and PC-relative;
- post-increment and pre-decrement of a pointer register;
- a two-step indirect form that first fetches a pointer word from memory.

A request is taken when `reqValid` and `reqReady` are both high. Every direct form gives its result exactly one cycle later. For the pointer-update forms, the new register value comes out on a writeback port with its own one-cycle enable. The indirect form sends one read to memory and waits for the word to return. It then offers that word as the final address. While it waits, it refuses new requests.

Top module: `eaGen`

## Requirements
- R1: Mode codes are REG=0, IMM=1, DISP=2, PTR=3, IDX=4, ABS=5, IND=6, POSTINC=7, PREDEC=8, SCALED=9, PCREL=10. The addresses are: DISP gives base+imm, PTR gives base, IDX gives base+index, ABS gives imm. All sums wrap modulo 2^AW.
- R2: PCREL gives pc+imm.
- R3: SCALED gives imm+base+(index shifted left by scaleLog2), where scaleLog2 is 0..3.
- R4: POSTINC gives base as the address and base+(1<<sizeLog2) as the writeback value.
- R5: PREDEC gives base-(1<<sizeLog2) both as the writeback value and as the address.
- R6: wbEn is high only together with addrValid, and only for a POSTINC or PREDEC result.
- R7: REG, IMM and the unused codes 11..15 give needsMem=0 and addrOut=0. Every other mode gives needsMem=1.
- R8: For any mode other than IND, addrValid is high for exactly the one cycle after acceptance. Back-to-back requests are accepted on consecutive cycles.
- R9: An accepted IND request raises memRdReq for exactly the next cycle, with memRdAddr=base. addrValid stays low until memRdValid is seen. In the cycle after that, addrValid is high with addrOut equal to memRdData.
- R10: From the cycle memRdReq is high until memRdValid arrives, reqReady is low and requests are not taken. Results always leave in acceptance order.
- R11: After reset, addrValid, wbEn and memRdReq are low and reqReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| reqMode | input | 4 | Addressing mode code |
| baseVal | input | AW | Base register value |
| indexVal | input | AW | Index register value |
| immVal | input | AW | Immediate / displacement, already sign-extended |
| pcVal | input | AW | Program counter of the instruction |
| sizeLog2 | input | 2 | log2 of element size in bytes |
| scaleLog2 | input | 2 | log2 of index scale |
| addrValid | output | 1 | Result present for one cycle |
| addrOut | output | AW | Effective address |
| needsMem | output | 1 | Result refers to memory |
| wbEn | output | 1 | Base register writeback enable |
| wbData | output | AW | Updated base register value |
| memRdReq | output | 1 | Pointer fetch request (one cycle) |
| memRdAddr | output | AW | Pointer fetch address |
| memRdValid | input | 1 | Pointer word returned |
| memRdData | input | AW | Returned pointer word |

## Verification
A controller stuck in its waiting state shows at once. reqReady stays low, and the next queued result never comes out, so the scoreboard times out. A controller that leaves the waiting state too early puts out a result before memRdValid arrives. That result carries the wrong address, and the comparison flags it in the same cycle. Wrong arithmetic for a mode, a swapped step direction, or a writeback flag left over from an earlier result each show up in the first result of that mode. Each mode is checked with distinct operand values, and the results are compared one cycle after acceptance.

// File: rtl/eaPkg.sv
`timescale 1ns/1ps
package eaPkg;
  typedef enum logic [3:0] {
    MODE_REG     = 4'd0,
    MODE_IMM     = 4'd1,
    MODE_DISP    = 4'd2,
    MODE_PTR     = 4'd3,
    MODE_IDX     = 4'd4,
    MODE_ABS     = 4'd5,
    MODE_IND     = 4'd6,
    MODE_POSTINC = 4'd7,
    MODE_PREDEC  = 4'd8,
    MODE_SCALED  = 4'd9,
    MODE_PCREL   = 4'd10
  } eaMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeDirect;   // capture computed result
    logic takeFetch;    // capture pointer fetch address
    logic takeReturn;   // capture returned pointer word
  } eaCtrl_t;
endpackage

// File: rtl/eaDatapath.sv
`timescale 1ns/1ps
module eaDatapath
  import eaPkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  eaCtrl_t       ctrl,
  input  logic [3:0]    reqMode,
  input  logic [AW-1:0] baseVal,
  input  logic [AW-1:0] indexVal,
  input  logic [AW-1:0] immVal,
  input  logic [AW-1:0] pcVal,
  input  logic [1:0]    sizeLog2,
  input  logic [1:0]    scaleLog2,
  input  logic [AW-1:0] memRdData,
  output logic [AW-1:0] addrQ,
  output logic          needsMemQ,
  output logic          wbFlagQ,
  output logic [AW-1:0] wbDataQ,
  output logic [AW-1:0] rdAddrQ
);
  localparam int SHW = 2;

  logic [AW-1:0] stepSize;
  logic [AW-1:0] scaledIdx;
  logic [AW-1:0] incVal;
  logic [AW-1:0] decVal;
  logic [AW-1:0] calcAddr;
  logic [AW-1:0] calcWb;
  logic          calcMem;
  logic          calcWbFlag;

  assign stepSize  = AW'(1) << sizeLog2;
  assign scaledIdx = indexVal << scaleLog2[SHW-1:0];
  assign incVal    = baseVal + stepSize;
  assign decVal    = baseVal - stepSize;

  always_comb begin
    calcAddr   = '0;
    calcWb     = '0;
    calcMem    = 1'b1;
    calcWbFlag = 1'b0;
    case (reqMode)
      MODE_DISP:    calcAddr = baseVal + immVal;
      MODE_PTR:     calcAddr = baseVal;
      MODE_IDX:     calcAddr = baseVal + indexVal;
      MODE_ABS:     calcAddr = immVal;
      MODE_IND:     calcAddr = baseVal;
      MODE_POSTINC: begin
        calcAddr   = baseVal;
        calcWb     = incVal;
        calcWbFlag = 1'b1;
      end
      MODE_PREDEC: begin
        calcAddr   = decVal;
        calcWb     = decVal;
        calcWbFlag = 1'b1;
      end
      MODE_SCALED:  calcAddr = immVal + baseVal + scaledIdx;
      MODE_PCREL:   calcAddr = pcVal + immVal;
      default:      calcMem  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      needsMemQ <= 1'b0;
      wbFlagQ   <= 1'b0;
      wbDataQ   <= '0;
      rdAddrQ   <= '0;
    end else begin
      if (ctrl.takeDirect) begin
        addrQ     <= calcAddr;
        needsMemQ <= calcMem;
        wbFlagQ   <= calcWbFlag;
        wbDataQ   <= calcWb;
      end else if (ctrl.takeReturn) begin
        addrQ     <= memRdData;
        needsMemQ <= 1'b1;
        wbFlagQ   <= 1'b0;
        wbDataQ   <= '0;
      end
      if (ctrl.takeFetch) rdAddrQ <= baseVal;
    end
  end
endmodule

// File: rtl/eaControl.sv
`timescale 1ns/1ps
module eaControl
  import eaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [3:0] reqMode,
  input  logic       memRdValid,
  output logic       reqReady,
  output eaCtrl_t    ctrl,
  output logic       validQ,
  output logic       rdReqQ
);
  typedef enum logic {ST_IDLE, ST_WAIT} eaState_e;
  eaState_e state;
  logic accept;
  logic isInd;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign isInd    = (reqMode == MODE_IND);

  always_comb begin
    ctrl.takeDirect = accept && !isInd;
    ctrl.takeFetch  = accept && isInd;
    ctrl.takeReturn = (state == ST_WAIT) && memRdValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      validQ <= 1'b0;
      rdReqQ <= 1'b0;
    end else begin
      validQ <= ctrl.takeDirect || ctrl.takeReturn;
      rdReqQ <= ctrl.takeFetch;
      if (ctrl.takeFetch)       state <= ST_WAIT;
      else if (ctrl.takeReturn) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/eaGen.sv
`timescale 1ns/1ps
module eaGen
  import eaPkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [3:0]    reqMode,
  input  logic [AW-1:0] baseVal,
  input  logic [AW-1:0] indexVal,
  input  logic [AW-1:0] immVal,
  input  logic [AW-1:0] pcVal,
  input  logic [1:0]    sizeLog2,
  input  logic [1:0]    scaleLog2,
  output logic          addrValid,
  output logic [AW-1:0] addrOut,
  output logic          needsMem,
  output logic          wbEn,
  output logic [AW-1:0] wbData,
  output logic          memRdReq,
  output logic [AW-1:0] memRdAddr,
  input  logic          memRdValid,
  input  logic [AW-1:0] memRdData
);
  eaCtrl_t ctrl;
  logic    wbFlag;

  eaControl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .memRdValid(memRdValid), .reqReady(reqReady), .ctrl(ctrl),
    .validQ(addrValid), .rdReqQ(memRdReq)
  );

  eaDatapath #(.AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqMode(reqMode),
    .baseVal(baseVal), .indexVal(indexVal), .immVal(immVal), .pcVal(pcVal),
    .sizeLog2(sizeLog2), .scaleLog2(scaleLog2), .memRdData(memRdData),
    .addrQ(addrOut), .needsMemQ(needsMem), .wbFlagQ(wbFlag),
    .wbDataQ(wbData), .rdAddrQ(memRdAddr)
  );

  assign wbEn = addrValid && wbFlag;
endmodule

// File: rtl/eaGenChk.sv
`timescale 1ns/1ps
module eaGenChk
  import eaPkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic [3:0]    reqMode,
  input logic [AW-1:0] baseVal,
  input logic          addrValid,
  input logic [AW-1:0] addrOut,
  input logic          needsMem,
  input logic          wbEn,
  input logic [AW-1:0] wbData,
  input logic          memRdReq
);
  logic taken;
  assign taken = reqValid && reqReady;

  AST_WB_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> addrValid); // R6
  AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqMode != MODE_IND) |=> addrValid); // R8
  AST_FETCH_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqMode == MODE_IND) |=> (memRdReq && !addrValid)); // R9
  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> !memRdReq); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> !reqReady); // R10
  AST_REG_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqMode == MODE_REG) |=> (!needsMem && !wbEn)); // R7
  AST_POSTINC_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqMode == MODE_POSTINC) |=> (addrOut == $past(baseVal) && wbEn)); // R4
  AST_PREDEC_NEW: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqMode == MODE_PREDEC) |=> (addrOut == wbData && wbEn)); // R5
endmodule

bind eaGen eaGenChk #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqMode(reqMode), .baseVal(baseVal), .addrValid(addrValid),
  .addrOut(addrOut), .needsMem(needsMem), .wbEn(wbEn), .wbData(wbData),
  .memRdReq(memRdReq)
);

// File: tb/eaGen_test.sv
`timescale 1ns/1ps
module eaGen_test;
  localparam int AW = 32;
  localparam logic [AW-1:0] MEMKEY = 32'h5A5A_0F0F;

  typedef struct {
    logic [AW-1:0] addr;
    logic          mem;
    logic          wb;
    logic [AW-1:0] wbv;
    string         tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [3:0] reqMode = '0;
  logic [AW-1:0] baseVal = '0, indexVal = '0, immVal = '0, pcVal = '0;
  logic [1:0] sizeLog2 = '0, scaleLog2 = '0;
  logic addrValid, needsMem, wbEn, memRdReq;
  logic [AW-1:0] addrOut, wbData, memRdAddr;
  logic memRdValid = 1'b0;
  logic [AW-1:0] memRdData = '0;

  int checks = 0;
  int fails = 0;
  int respDelay = 0;
  logic [AW-1:0] lastIndBase = '0;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  eaGen #(.AW(AW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .baseVal(baseVal), .indexVal(indexVal),
    .immVal(immVal), .pcVal(pcVal), .sizeLog2(sizeLog2),
    .scaleLog2(scaleLog2), .addrValid(addrValid), .addrOut(addrOut),
    .needsMem(needsMem), .wbEn(wbEn), .wbData(wbData),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr),
    .memRdValid(memRdValid), .memRdData(memRdData)
  );

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, returns at a negedge
  task automatic send(input logic [3:0] m, input logic [AW-1:0] b, input logic [AW-1:0] x,
                      input logic [AW-1:0] im, input logic [AW-1:0] pc,
                      input logic [1:0] sz, input logic [1:0] sc, input string tag);
    expItem_t e;
    logic [AW-1:0] step;
    step = AW'(1) << sz;
    e.addr = '0; e.mem = 1'b1; e.wb = 1'b0; e.wbv = '0; e.tag = tag;
    case (m)
      4'd2:  e.addr = b + im;
      4'd3:  e.addr = b;
      4'd4:  e.addr = b + x;
      4'd5:  e.addr = im;
      4'd6:  e.addr = b ^ MEMKEY;
      4'd7:  begin e.addr = b; e.wb = 1'b1; e.wbv = b + step; end
      4'd8:  begin e.addr = b - step; e.wb = 1'b1; e.wbv = b - step; end
      4'd9:  e.addr = im + b + (x << sc);
      4'd10: e.addr = pc + im;
      default: e.mem = 1'b0;
    endcase
    reqMode = m; baseVal = b; indexVal = x; immVal = im; pcVal = pc;
    sizeLog2 = sz; scaleLog2 = sc; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    if (m == 4'd6) lastIndBase = b;
    expQ.push_back(e);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (addrValid) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R10 unexpected result", addrOut, '0);
          end else begin
            expItem_t e;
            e = expQ.pop_front();
            check(addrOut == e.addr, {e.tag, " addr"}, addrOut, e.addr);
            check(needsMem == e.mem, {e.tag, " R7 needsMem"}, AW'(needsMem), AW'(e.mem));
            check(wbEn == e.wb, {e.tag, " R6 wbEn"}, AW'(wbEn), AW'(e.wb));
            if (e.wb) check(wbData == e.wbv, {e.tag, " wbData"}, wbData, e.wbv);
          end
        end else if (wbEn) begin
          check(1'b0, "R6 wbEn without valid", AW'(wbEn), '0);
        end
      end
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && memRdReq) begin
        check(memRdAddr == lastIndBase, "R9 memRdAddr", memRdAddr, lastIndBase);
        check(!reqReady, "R10 ready low while fetching", AW'(reqReady), '0);
        for (int i = 0; i < respDelay; i++) begin
          check(!addrValid, "R9 no result before return", AW'(addrValid), '0);
          check(!memRdReq || i == 0 ? 1'b1 : 1'b0, "R9 memRdReq single pulse", AW'(memRdReq), '0);
          @(negedge clk);
          check(!reqReady, "R10 still busy", AW'(reqReady), '0);
        end
        memRdData = memRdAddr ^ MEMKEY;
        memRdValid = 1'b1;
        @(negedge clk);
        memRdValid = 1'b0;
        memRdData = '0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired with %0d results pending", expQ.size());
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    check(!addrValid, "R11 addrValid", AW'(addrValid), '0);
    check(!wbEn, "R11 wbEn", AW'(wbEn), '0);
    check(!memRdReq, "R11 memRdReq", AW'(memRdReq), '0);
    check(reqReady, "R11 reqReady", AW'(reqReady), 1);

    // R1 basic modes, back-to-back (R8)
    send(4'd2, 32'h0000_1000, 32'h0, 32'hFFFF_FFF0, 32'h0, 2'd0, 2'd0, "R1 disp negative");
    send(4'd3, 32'h1234_5678, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, "R1 ptr");
    send(4'd4, 32'h0000_0100, 32'h0000_0024, 32'h0, 32'h0, 2'd0, 2'd0, "R1 idx");
    send(4'd5, 32'hDEAD_0000, 32'h0, 32'h0000_BEEF, 32'h0, 2'd0, 2'd0, "R1 abs");
    send(4'd2, 32'hFFFF_FFFF, 32'h0, 32'h0000_0002, 32'h0, 2'd0, 2'd0, "R1 disp wrap");
    // R2
    send(4'd10, 32'h0, 32'h0, 32'h0000_0040, 32'h0040_0000, 2'd0, 2'd0, "R2 pcrel");
    send(4'd10, 32'h0, 32'h0, 32'hFFFF_FF00, 32'h0040_0000, 2'd0, 2'd0, "R2 pcrel back");
    // R3 each scale
    for (int s = 0; s < 4; s++)
      send(4'd9, 32'h0000_2000, 32'h0000_0003, 32'h0000_0010, 32'h0, 2'd0, 2'(s), "R3 scaled");
    // R4 / R5 each size
    for (int z = 0; z < 4; z++) begin
      send(4'd7, 32'h0000_8000, 32'h0, 32'h0, 32'h0, 2'(z), 2'd0, "R4 postinc");
      send(4'd8, 32'h0000_8000, 32'h0, 32'h0, 32'h0, 2'(z), 2'd0, "R5 predec");
    end
    send(4'd8, 32'h0000_0002, 32'h0, 32'h0, 32'h0, 2'd2, 2'd0, "R5 predec wrap");
    // R7 non-memory and unused codes
    send(4'd0, 32'h1111_1111, 32'h2, 32'h3, 32'h4, 2'd3, 2'd3, "R7 reg");
    send(4'd1, 32'h1111_1111, 32'h2, 32'h3, 32'h4, 2'd3, 2'd3, "R7 imm");
    send(4'd13, 32'h1111_1111, 32'h2, 32'h3, 32'h4, 2'd3, 2'd3, "R7 unused");
    // R6: postinc then plain mode, wbEn must drop
    send(4'd7, 32'h0000_0400, 32'h0, 32'h0, 32'h0, 2'd1, 2'd0, "R6 postinc");
    send(4'd3, 32'h0000_0400, 32'h0, 32'h0, 32'h0, 2'd1, 2'd0, "R6 ptr after postinc");
    // R9 / R10 indirect with several delays, a request waiting behind it
    respDelay = 0;
    send(4'd6, 32'h0000_3000, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, "R9 ind fast");
    send(4'd4, 32'h0000_0010, 32'h0000_0001, 32'h0, 32'h0, 2'd0, 2'd0, "R10 after ind");
    respDelay = 5;
    send(4'd6, 32'hABCD_0000, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, "R9 ind slow");
    send(4'd7, 32'h0000_0020, 32'h0, 32'h0, 32'h0, 2'd3, 2'd0, "R10 queued postinc");
    respDelay = 2;
    send(4'd6, 32'h0000_0004, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, "R9 ind mid");
    send(4'd6, 32'h0000_0008, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, "R9 ind twice");

    repeat (12) @(negedge clk);
    check(expQ.size() == 0, "R8 results drained", AW'(expQ.size()), '0);
    check(!addrValid && !memRdReq, "R8 idle at end", AW'({addrValid, memRdReq}), '0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule